// File: doc/BRIEF.md
# Lazy Transactional Write Buffer

This block holds a transaction's speculative stores to lines already known to be contended, one entry per data word, while the rest of the write set is updated in place elsewhere. Buffered stores stay private: they raise no ownership request and no memory write until the transaction commits. Loads from the core probe the buffer and get the buffered bytes back on a hit, so the transaction sees its own writes.

On commit, a non-empty buffer first requests the global commit token and waits for it. It then walks its entries in allocation order. Each time it reaches a line it has not just claimed, it issues a non-transactional upgrade for exclusive ownership, emits the completion (unblock) message flagged as commit traffic once the upgrade is acknowledged, and then writes the word out. The token is released with a done pulse right after the last write. An empty buffer completes a commit at once without touching the token. An abort throws every entry away in a single cycle. When all entries are used, a store to a word not yet buffered is sent to the cache instead, but only after shared access to its line has been obtained so the old value survives.

The token arbiter, the private cache, and the coherence fabric are outside the block and appear as request/acknowledge pairs.

Top module: `lazy_write_buf`

## Requirements
- R1: The buffer holds up to DEPTH (default 32) distinct words. Each store to a word not yet held takes a new entry. `ovf` is high exactly when all DEPTH entries are in use.
- R2: A store to a word already held does not take a new entry. Its enabled bytes overwrite the old ones, and the entry's byte-enable mask becomes the OR of the old and new masks. `st_be[b]` covers data bits 8b+7..8b.
- R3: A load presented with `ld_valid` gives `ld_hit`, `ld_be` and `ld_data` on the next cycle. On a hit these hold the entry's mask and bytes. On a miss, `ld_hit` and `ld_be` are 0.
- R4: Accepting stores produces no `tok_req`, `upg_req`, `ub_valid` or `wr_valid`.
- R5: A commit with at least one entry raises `tok_req` and holds it until `tok_grant`. No upgrade or write appears before the grant.
- R6: The drain visits entries in allocation order. It issues `upg_req` with the line-aligned address for the first entry and for every entry whose line differs from the previous entry's line. After `upg_ack`, it gives one cycle of `ub_valid` with `ub_commit` high. It then gives one `wr_valid` cycle carrying the word's address, data and mask.
- R7: `tok_rel` and `cmt_done` pulse together in the cycle after the last drain write. Afterwards the buffer is empty.
- R8: A commit with no entries pulses `cmt_done` in the next cycle and never raises `tok_req` or `tok_rel`.
- R9: An abort while idle or while waiting for the token empties the buffer in one cycle and drops any token request. A later commit is then empty.
- R10: When the buffer is full, a store to a new word lowers `st_ready` and raises `shr_req` with the line-aligned address until `shr_ack`. It then gives one `cwr_valid` cycle carrying the store. A store to an already held word still merges into the buffer (R2).
- R11: After reset the buffer is empty, `st_ready` is high, and every request and strobe output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Contended-line store request |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte enables |
| st_ready | output | 1 | Buffer idle and taking stores |
| ld_valid | input | 1 | Load probe |
| ld_addr | input | ADDR_W | Load byte address |
| ld_hit | output | 1 | Probe hit (one cycle later) |
| ld_data | output | DATA_W | Buffered data on hit |
| ld_be | output | DATA_W/8 | Valid bytes of the buffered word |
| cmt_req | input | 1 | Commit request pulse |
| abt_req | input | 1 | Abort request pulse |
| cmt_done | output | 1 | Commit complete pulse |
| tok_req | output | 1 | Global commit token request |
| tok_grant | input | 1 | Token held by this buffer |
| tok_rel | output | 1 | Token release pulse |
| upg_req | output | 1 | Non-transactional upgrade request |
| upg_addr | output | ADDR_W | Line-aligned upgrade address |
| upg_ack | input | 1 | Exclusive ownership granted |
| ub_valid | output | 1 | Unblock message strobe |
| ub_commit | output | 1 | Commit flag of the unblock message |
| wr_valid | output | 1 | Drain write strobe |
| wr_addr | output | ADDR_W | Drain write word address |
| wr_data | output | DATA_W | Drain write data |
| wr_be | output | DATA_W/8 | Drain write byte mask |
| ovf | output | 1 | All entries in use |
| shr_req | output | 1 | Shared-access request for a fallback store |
| shr_addr | output | ADDR_W | Line-aligned fallback address |
| shr_ack | input | 1 | Shared access obtained, old value safe |
| cwr_valid | output | 1 | Fallback store to cache strobe |
| cwr_addr | output | ADDR_W | Fallback store address |
| cwr_data | output | DATA_W | Fallback store data |
| cwr_be | output | DATA_W/8 | Fallback store byte enables |

## Verification
The drain is tried with a mixed set: two words sharing one line followed by a word on another line. This separates a buffer that upgrades once per line from one that upgrades once per entry or once per transaction. The set also includes a partially merged word, which shows whether byte masks are ORed or replaced. A full buffer of consecutive words over two lines checks capacity, the overflow flag, the fallback path, and merging while full. Empty commits, and aborts taken while idle and while the token request is pending, show that discarding is immediate and that no token is requested when nothing is buffered.

// File: rtl/lwb_pkg.sv
package lwb_pkg;
  typedef enum logic [3:0] {
    S_IDLE,   // taking stores
    S_FBA,    // fallback: waiting for shared access
    S_FBW,    // fallback: store goes to cache
    S_TOK,    // waiting for commit token
    S_RD,     // read next entry
    S_UPG,    // upgrade outstanding
    S_UB,     // unblock with commit flag
    S_WR,     // drain write
    S_FIN,    // release token, done
    S_EMPTY   // empty commit done
  } lwb_state_e;
endpackage

// File: rtl/lwb_tags.sv
module lwb_tags #(
  parameter int DEPTH = 32,
  parameter int TAG_W = 30,
  parameter int BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clear,
  input  logic                          alloc_we,
  input  logic                          merge_we,
  input  logic [TAG_W-1:0]              st_tag,
  input  logic [BYTES-1:0]              wr_be,
  input  logic [TAG_W-1:0]              ld_tag,
  input  logic [$clog2(DEPTH)-1:0]      rd_idx,
  output logic                          st_hit,
  output logic [$clog2(DEPTH)-1:0]      st_idx,
  output logic                          ld_hit,
  output logic [$clog2(DEPTH)-1:0]      ld_idx,
  output logic [BYTES-1:0]              ld_be,
  output logic [$clog2(DEPTH+1)-1:0]    count,
  output logic [TAG_W-1:0]              rd_tag,
  output logic [BYTES-1:0]              rd_be
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [BYTES-1:0] be_q  [DEPTH];
  logic [CNT_W-1:0] count_q;

  // associative match over the occupied entries
  always_comb begin
    st_hit = 1'b0;
    st_idx = '0;
    ld_hit = 1'b0;
    ld_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i) < count_q) begin
        if (tag_q[i] == st_tag) begin
          st_hit = 1'b1;
          st_idx = IDX_W'(i);
        end
        if (tag_q[i] == ld_tag) begin
          ld_hit = 1'b1;
          ld_idx = IDX_W'(i);
        end
      end
    end
  end

  assign ld_be  = be_q[ld_idx];
  assign rd_tag = tag_q[rd_idx];
  assign rd_be  = be_q[rd_idx];
  assign count  = count_q;

  always_ff @(posedge clk) begin
    if (rst)           count_q <= '0;
    else if (clear)    count_q <= '0;
    else if (alloc_we) count_q <= count_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (alloc_we) begin
      tag_q[count_q[IDX_W-1:0]] <= st_tag;
      be_q[count_q[IDX_W-1:0]]  <= wr_be;
    end else if (merge_we) begin
      be_q[st_idx] <= be_q[st_idx] | wr_be;
    end
  end

  // R1: never allocate past capacity
  a_r1_alloc_room: assert property (@(posedge clk) disable iff (rst)
    alloc_we |-> (count_q < CNT_W'(DEPTH)));
  // R2: a word already held is merged, never allocated twice
  a_r2_alloc_unique: assert property (@(posedge clk) disable iff (rst)
    alloc_we |-> !st_hit);
  a_r2_merge_hit: assert property (@(posedge clk) disable iff (rst)
    merge_we |-> st_hit);
endmodule

// File: rtl/lwb_data.sv
module lwb_data #(
  parameter int DEPTH = 32,
  parameter int BYTES = 4
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [BYTES-1:0]          wbe,
  input  logic [$clog2(DEPTH)-1:0]  widx,
  input  logic [8*BYTES-1:0]        wdata,
  input  logic [$clog2(DEPTH)-1:0]  ra,
  input  logic [$clog2(DEPTH)-1:0]  rb,
  output logic [8*BYTES-1:0]        qa,
  output logic [8*BYTES-1:0]        qb
);
  // one byte-wide memory per lane, synchronous reads on two ports
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] qa_l;
    logic [7:0] qb_l;
    always_ff @(posedge clk) begin
      if (we && wbe[g]) mem[widx] <= wdata[8*g +: 8];
      qa_l <= mem[ra];
      qb_l <= mem[rb];
    end
    assign qa[8*g +: 8] = qa_l;
    assign qb[8*g +: 8] = qb_l;
  end
endmodule

// File: rtl/lazy_write_buf.sv
module lazy_write_buf
  import lwb_pkg::*;
#(
  parameter int DEPTH      = 32,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                st_valid,
  input  logic [ADDR_W-1:0]   st_addr,
  input  logic [DATA_W-1:0]   st_data,
  input  logic [DATA_W/8-1:0] st_be,
  output logic                st_ready,
  input  logic                ld_valid,
  input  logic [ADDR_W-1:0]   ld_addr,
  output logic                ld_hit,
  output logic [DATA_W-1:0]   ld_data,
  output logic [DATA_W/8-1:0] ld_be,
  input  logic                cmt_req,
  input  logic                abt_req,
  output logic                cmt_done,
  output logic                tok_req,
  input  logic                tok_grant,
  output logic                tok_rel,
  output logic                upg_req,
  output logic [ADDR_W-1:0]   upg_addr,
  input  logic                upg_ack,
  output logic                ub_valid,
  output logic                ub_commit,
  output logic                wr_valid,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W/8-1:0] wr_be,
  output logic                ovf,
  output logic                shr_req,
  output logic [ADDR_W-1:0]   shr_addr,
  input  logic                shr_ack,
  output logic                cwr_valid,
  output logic [ADDR_W-1:0]   cwr_addr,
  output logic [DATA_W-1:0]   cwr_data,
  output logic [DATA_W/8-1:0] cwr_be
);
  localparam int BYTES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(BYTES);
  localparam int WA_W   = ADDR_W - OFF_W;
  localparam int LOFF_W = $clog2(LINE_BYTES);
  localparam int LSH    = LOFF_W - OFF_W;
  localparam int LN_W   = WA_W - LSH;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH+1);

  lwb_state_e state;

  logic [WA_W-1:0]  st_tag, ld_tag;
  logic             st_hit, ld_m;
  logic [IDX_W-1:0] st_idx, ld_idx, wi;
  logic [BYTES-1:0] ld_ebe, rd_be;
  logic [CNT_W-1:0] count;
  logic [WA_W-1:0]  rd_tag;
  logic [LN_W-1:0]  rd_line;
  logic [DATA_W-1:0] qa, qb;

  logic [CNT_W-1:0] ptr;
  logic             first_q;
  logic [LN_W-1:0]  last_line;
  logic [WA_W-1:0]  cur_tag;
  logic [BYTES-1:0] cur_be;
  logic [WA_W-1:0]  fb_tag;
  logic [DATA_W-1:0] fb_data;
  logic [BYTES-1:0] fb_be;
  logic             ld_hit_q;
  logic [BYTES-1:0] ld_be_q;

  logic full, store_fire, alloc_we, merge_we, to_fb, clear;
  logic unused_lo;

  assign st_tag    = st_addr[ADDR_W-1:OFF_W];
  assign ld_tag    = ld_addr[ADDR_W-1:OFF_W];
  assign unused_lo = ^{st_addr[OFF_W-1:0], ld_addr[OFF_W-1:0]};
  assign rd_line   = rd_tag[WA_W-1:LSH];

  assign full       = (count == CNT_W'(DEPTH));
  assign st_ready   = (state == S_IDLE);
  assign store_fire = st_valid && st_ready && !abt_req;
  assign merge_we   = store_fire && st_hit;
  assign alloc_we   = store_fire && !st_hit && !full;
  assign to_fb      = store_fire && !st_hit && full;
  assign clear      = (abt_req && (state == S_IDLE || state == S_TOK)) ||
                      (state == S_FIN);
  assign wi         = st_hit ? st_idx : count[IDX_W-1:0];

  lwb_tags #(.DEPTH(DEPTH), .TAG_W(WA_W), .BYTES(BYTES)) u_tags (
    .clk(clk), .rst(rst), .clear(clear),
    .alloc_we(alloc_we), .merge_we(merge_we),
    .st_tag(st_tag), .wr_be(st_be), .ld_tag(ld_tag),
    .rd_idx(ptr[IDX_W-1:0]),
    .st_hit(st_hit), .st_idx(st_idx),
    .ld_hit(ld_m), .ld_idx(ld_idx), .ld_be(ld_ebe),
    .count(count), .rd_tag(rd_tag), .rd_be(rd_be)
  );

  lwb_data #(.DEPTH(DEPTH), .BYTES(BYTES)) u_data (
    .clk(clk), .we(alloc_we || merge_we), .wbe(st_be), .widx(wi),
    .wdata(st_data), .ra(ptr[IDX_W-1:0]), .rb(ld_idx),
    .qa(qa), .qb(qb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      ptr       <= '0;
      first_q   <= 1'b0;
      last_line <= '0;
      cur_tag   <= '0;
      cur_be    <= '0;
      fb_tag    <= '0;
      fb_data   <= '0;
      fb_be     <= '0;
      ld_hit_q  <= 1'b0;
      ld_be_q   <= '0;
    end else begin
      ld_hit_q <= ld_valid && ld_m;
      ld_be_q  <= (ld_valid && ld_m) ? ld_ebe : '0;
      case (state)
        S_IDLE: begin
          if (abt_req) begin
            state <= S_IDLE;
          end else if (to_fb) begin
            fb_tag  <= st_tag;
            fb_data <= st_data;
            fb_be   <= st_be;
            state   <= S_FBA;
          end else if (!store_fire && cmt_req) begin
            state <= (count == '0) ? S_EMPTY : S_TOK;
          end
        end
        S_FBA: if (shr_ack) state <= S_FBW;
        S_FBW: state <= S_IDLE;
        S_TOK: begin
          if (abt_req) begin
            state <= S_IDLE;
          end else if (tok_grant) begin
            ptr     <= '0;
            first_q <= 1'b1;
            state   <= S_RD;
          end
        end
        S_RD: begin
          cur_tag   <= rd_tag;
          cur_be    <= rd_be;
          first_q   <= 1'b0;
          last_line <= rd_line;
          state     <= (first_q || rd_line != last_line) ? S_UPG : S_WR;
        end
        S_UPG: if (upg_ack) state <= S_UB;
        S_UB:  state <= S_WR;
        S_WR: begin
          ptr   <= ptr + CNT_W'(1);
          state <= (ptr + CNT_W'(1) == count) ? S_FIN : S_RD;
        end
        S_FIN:   state <= S_IDLE;
        S_EMPTY: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign tok_req   = (state == S_TOK);
  assign upg_req   = (state == S_UPG);
  assign upg_addr  = {cur_tag[WA_W-1:LSH], {LOFF_W{1'b0}}};
  assign ub_valid  = (state == S_UB);
  assign ub_commit = (state == S_UB);
  assign wr_valid  = (state == S_WR);
  assign wr_addr   = {cur_tag, {OFF_W{1'b0}}};
  assign wr_data   = qa;
  assign wr_be     = cur_be;
  assign tok_rel   = (state == S_FIN);
  assign cmt_done  = (state == S_FIN) || (state == S_EMPTY);
  assign ovf       = full;
  assign shr_req   = (state == S_FBA);
  assign shr_addr  = {fb_tag[WA_W-1:LSH], {LOFF_W{1'b0}}};
  assign cwr_valid = (state == S_FBW);
  assign cwr_addr  = {fb_tag, {OFF_W{1'b0}}};
  assign cwr_data  = fb_data;
  assign cwr_be    = fb_be;
  assign ld_hit    = ld_hit_q;
  assign ld_be     = ld_be_q;
  assign ld_data   = qb;

  // R5: drain traffic only while the token is granted
  a_r5_drain_granted: assert property (@(posedge clk) disable iff (rst)
    (upg_req || wr_valid) |-> tok_grant);
  // R6: unblock follows an acknowledged upgrade
  a_r6_ub_after_ack: assert property (@(posedge clk) disable iff (rst)
    ub_valid |-> $past(upg_req && upg_ack));
  // R7: token released right after a drain write
  a_r7_rel_after_write: assert property (@(posedge clk) disable iff (rst)
    tok_rel |-> ($past(wr_valid) && cmt_done));
  // R8: an empty commit finishes one cycle after the request
  a_r8_empty_fast: assert property (@(posedge clk) disable iff (rst)
    (cmt_done && !tok_rel) |-> $past(cmt_req && count == '0));
  // R9: abort empties the buffer in one cycle
  a_r9_abort_empties: assert property (@(posedge clk) disable iff (rst)
    (abt_req && (state == S_IDLE || state == S_TOK)) |=> (count == '0));
  // R10: fallback cache write only after shared access was granted
  a_r10_cwr_after_shr: assert property (@(posedge clk) disable iff (rst)
    cwr_valid |-> $past(shr_req && shr_ack));
endmodule

// File: tb/lazy_write_buf_bench.sv
`timescale 1ns/1ps
module lazy_write_buf_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic [3:0]  st_be = '0;
  logic        st_ready;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_addr = '0;
  logic        ld_hit;
  logic [31:0] ld_data;
  logic [3:0]  ld_be;
  logic        cmt_req = 1'b0;
  logic        abt_req = 1'b0;
  logic        cmt_done, tok_req, tok_rel;
  logic        tok_grant = 1'b0;
  logic        upg_req;
  logic [31:0] upg_addr;
  logic        upg_ack = 1'b0;
  logic        ub_valid, ub_commit, wr_valid;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  wr_be;
  logic        ovf, shr_req;
  logic [31:0] shr_addr;
  logic        shr_ack = 1'b0;
  logic        cwr_valid;
  logic [31:0] cwr_addr, cwr_data;
  logic [3:0]  cwr_be;

  always #10 clk = ~clk;

  lazy_write_buf u_lazy_write_buf (
    .clk(clk), .rst(rst),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .st_ready(st_ready),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
    .ld_be(ld_be),
    .cmt_req(cmt_req), .abt_req(abt_req), .cmt_done(cmt_done),
    .tok_req(tok_req), .tok_grant(tok_grant), .tok_rel(tok_rel),
    .upg_req(upg_req), .upg_addr(upg_addr), .upg_ack(upg_ack),
    .ub_valid(ub_valid), .ub_commit(ub_commit),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .ovf(ovf), .shr_req(shr_req), .shr_addr(shr_addr), .shr_ack(shr_ack),
    .cwr_valid(cwr_valid), .cwr_addr(cwr_addr), .cwr_data(cwr_data),
    .cwr_be(cwr_be)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int tok_dly = 6;
  int tok_cnt = 0;
  int grant_cyc = 0;
  int upg_cnt = 0;
  int shr_cnt = 0;

  // event log: 1 upg, 2 unblock, 3 drain write, 4 done, 5 release,
  // 6 token request, 7 cache write, 8 shared request
  int          ev_n = 0;
  int          ev_kind [256];
  int          ev_cyc  [256];
  logic [31:0] ev_addr [256];
  logic [31:0] ev_dat  [256];
  logic [3:0]  ev_be   [256];
  logic tok_req_d = 1'b0, upg_req_d = 1'b0, shr_req_d = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // token arbiter model
  always @(negedge clk) begin
    if (rst || tok_rel) begin
      tok_grant = 1'b0;
      tok_cnt   = 0;
    end else if (tok_req && !tok_grant) begin
      tok_cnt++;
      if (tok_cnt >= tok_dly) begin
        tok_grant = 1'b1;
        grant_cyc = cyc;
        tok_cnt   = 0;
      end
    end else if (!tok_req) begin
      tok_cnt = 0;
    end
  end

  // coherence fabric model
  always @(negedge clk) begin
    if (upg_req && !upg_ack) begin
      upg_cnt++;
      if (upg_cnt >= 2) begin upg_ack = 1'b1; upg_cnt = 0; end
    end else upg_ack = 1'b0;
    if (shr_req && !shr_ack) begin
      shr_cnt++;
      if (shr_cnt >= 3) begin shr_ack = 1'b1; shr_cnt = 0; end
    end else shr_ack = 1'b0;
  end

  function automatic void add(int k, logic [31:0] a, logic [31:0] d, logic [3:0] b);
    if (ev_n < 256) begin
      ev_kind[ev_n] = k; ev_cyc[ev_n] = cyc;
      ev_addr[ev_n] = a; ev_dat[ev_n] = d; ev_be[ev_n] = b;
      ev_n++;
    end
  endfunction

  always begin
    @(negedge clk);
    #1;
    if (!rst) begin
      if (tok_req && !tok_req_d) add(6, 0, 0, 0);
      if (upg_req && !upg_req_d) add(1, upg_addr, 0, 0);
      if (ub_valid)              add(2, 0, {31'b0, ub_commit}, 0);
      if (wr_valid)              add(3, wr_addr, wr_data, wr_be);
      if (shr_req && !shr_req_d) add(8, shr_addr, 0, 0);
      if (cwr_valid)             add(7, cwr_addr, cwr_data, cwr_be);
      if (tok_rel)               add(5, 0, 0, 0);
      if (cmt_done)              add(4, 0, 0, 0);
    end
    tok_req_d = tok_req; upg_req_d = upg_req; shr_req_d = shr_req;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_store(logic [31:0] a, logic [31:0] d, logic [3:0] b);
    while (!st_ready) @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d; st_be = b;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic do_load(logic [31:0] a, output logic h, output logic [31:0] d,
                         output logic [3:0] b);
    ld_valid = 1'b1; ld_addr = a;
    @(negedge clk);
    ld_valid = 1'b0;
    h = ld_hit; d = ld_data; b = ld_be;
  endtask

  task automatic do_commit(output int b, output int lat);
    int t = 0;
    b = ev_n;
    cmt_req = 1'b1;
    @(negedge clk);
    cmt_req = 1'b0;
    while (!cmt_done && t < 5000) begin @(negedge clk); t++; end
    lat = t;
    @(negedge clk);
  endtask

  function automatic logic [31:0] bmask(logic [3:0] b);
    return {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
  endfunction

  task automatic t_reset();
    logic h; logic [31:0] d; logic [3:0] b;
    chk("R11", "st_ready", {31'b0, st_ready}, 1);
    chk("R11", "requests", {26'b0, ovf, tok_req, upg_req, wr_valid, shr_req, cwr_valid}, 0);
    chk("R11", "done/rel", {30'b0, cmt_done, tok_rel}, 0);
    do_load(32'h100, h, d, b);
    chk("R11", "empty load hit", {31'b0, h}, 0);
  endtask

  task automatic t_mixed();
    logic h; logic [31:0] d; logic [3:0] b;
    int s, base, lat, fu;
    int exp_k [10] = '{6, 1, 2, 3, 3, 1, 2, 3, 5, 4};
    s = ev_n;
    do_store(32'h100, 32'h11223344, 4'b0001);
    do_store(32'h100, 32'hAABBCCDD, 4'b1100);
    do_store(32'h104, 32'h55667788, 4'b1111);
    do_store(32'h200, 32'h99AABBCC, 4'b0011);
    @(negedge clk);
    chk("R4", "traffic while storing", ev_n - s, 0);
    do_load(32'h100, h, d, b);
    chk("R3", "hit merged word", {31'b0, h}, 1);
    chk("R2", "merged mask", {28'b0, b}, 4'b1101);
    chk("R2", "merged bytes", d & bmask(4'b1101), 32'hAABB0044);
    do_load(32'h104, h, d, b);
    chk("R3", "full word data", d, 32'h55667788);
    do_load(32'h300, h, d, b);
    chk("R3", "miss hit flag", {28'b0, b, h}, 0);
    tok_dly = 8;
    do_commit(base, lat);
    chk("R6", "event count", ev_n - base, 10);
    if (ev_n - base == 10) begin
      for (int i = 0; i < 10; i++) chk("R6", "event order", ev_kind[base+i], exp_k[i]);
      chk("R6", "upgrade line A", ev_addr[base+1], 32'h100);
      chk("R6", "unblock commit flag", ev_dat[base+2], 1);
      chk("R2", "drain merged data", ev_dat[base+3] & bmask(ev_be[base+3]), 32'hAABB0044);
      chk("R2", "drain merged mask", {28'b0, ev_be[base+3]}, 4'b1101);
      chk("R6", "second word addr", ev_addr[base+4], 32'h104);
      chk("R6", "upgrade line B", ev_addr[base+5], 32'h200);
      chk("R6", "third word data", ev_dat[base+7] & 32'hFFFF, 32'hBBCC);
      fu = ev_cyc[base+1];
      chk("R5", "traffic after grant", {31'b0, fu > grant_cyc}, 1);
      chk("R7", "release after last write", ev_cyc[base+8], ev_cyc[base+7] + 1);
      chk("R7", "done with release", ev_cyc[base+9], ev_cyc[base+8]);
    end
    do_load(32'h100, h, d, b);
    chk("R7", "emptied after commit", {31'b0, h}, 0);
  endtask

  task automatic t_empty();
    int base, lat;
    do_commit(base, lat);
    chk("R8", "empty commit latency", lat, 0);
    chk("R8", "no token traffic", ev_n - base, 1);
    if (ev_n - base >= 1) chk("R8", "done event", ev_kind[base], 4);
  endtask

  task automatic t_abort();
    logic h; logic [31:0] d; logic [3:0] b;
    int base, lat;
    do_store(32'h300, 32'h01020304, 4'b1111);
    do_store(32'h340, 32'h05060708, 4'b1111);
    abt_req = 1'b1;
    @(negedge clk);
    abt_req = 1'b0;
    do_load(32'h300, h, d, b);
    chk("R9", "discarded on abort", {31'b0, h}, 0);
    do_commit(base, lat);
    chk("R9", "commit after abort empty", lat, 0);
    // abort while waiting for the token
    tok_dly = 1000;
    do_store(32'h400, 32'h0A0B0C0D, 4'b1111);
    cmt_req = 1'b1;
    @(negedge clk);
    cmt_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5", "token requested", {31'b0, tok_req}, 1);
    abt_req = 1'b1;
    @(negedge clk);
    abt_req = 1'b0;
    chk("R9", "token request dropped", {31'b0, tok_req}, 0);
    tok_dly = 2;
    do_commit(base, lat);
    chk("R9", "commit after wait-abort empty", lat, 0);
  endtask

  task automatic t_full();
    logic h; logic [31:0] d; logic [3:0] b;
    int s, base, lat, nw, nu;
    for (int i = 0; i < 32; i++) begin
      do_store(32'h1000 + 32'(4*i), 32'hA0000000 + 32'(i), 4'b1111);
      if (i == 30) chk("R1", "ovf below capacity", {31'b0, ovf}, 0);
    end
    chk("R1", "ovf at capacity", {31'b0, ovf}, 1);
    s = ev_n;
    do_store(32'h1000, 32'h000000EE, 4'b0001);
    chk("R10", "merge while full keeps ready", {31'b0, st_ready}, 1);
    do_store(32'h2004, 32'hCAFEF00D, 4'b1111);
    chk("R10", "ready low in fallback", {31'b0, st_ready}, 0);
    chk("R10", "shared request", {31'b0, shr_req}, 1);
    chk("R10", "shared line address", shr_addr, 32'h2000);
    chk("R10", "no cache write before ack", {31'b0, cwr_valid}, 0);
    repeat (8) @(negedge clk);
    chk("R10", "fallback events", ev_n - s, 2);
    if (ev_n - s == 2) begin
      chk("R10", "order shr then cwr", ev_kind[s+1], 7);
      chk("R10", "cache write addr", ev_addr[s+1], 32'h2004);
      chk("R10", "cache write data", ev_dat[s+1], 32'hCAFEF00D);
    end
    chk("R1", "still full", {31'b0, ovf}, 1);
    do_load(32'h2004, h, d, b);
    chk("R10", "fallback word not buffered", {31'b0, h}, 0);
    do_commit(base, lat);
    nw = 0; nu = 0;
    for (int i = base; i < ev_n; i++) begin
      if (ev_kind[i] == 3) begin
        if (nw == 0) chk("R2", "merged first word", ev_dat[i], 32'hA00000EE);
        if (nw == 31) chk("R6", "last word addr", ev_addr[i], 32'h107C);
        nw++;
      end
      if (ev_kind[i] == 1) begin
        chk("R6", "upgrade line", ev_addr[i], 32'h1000 + 32'(64*nu));
        nu++;
      end
    end
    chk("R1", "drained words", nw, 32);
    chk("R6", "upgrades per line", nu, 2);
    chk("R7", "ovf cleared", {31'b0, ovf}, 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mixed();
    t_empty();
    t_abort();
    t_full();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end
endmodule